// File: doc/BRIEF.md
# DMA Remapping Translation Unit

This block sits between bus-mastering devices and system memory and turns each device DMA request into a system physical address or refuses it. A request carries a 16-bit requester ID, a 64-bit device address and a direction flag. The unit resolves the requester to a protection domain through two in-memory tables indexed by the requester ID. It then walks that domain's three-level page tables over a single-outstanding read port, checking read/write permission at every level. It answers with a 52-bit physical address or a fault code.

A device whose context entry carries no domain is refused with no page-table read. Table entries that are missing end the walk immediately, because there is no demand paging. A level-2 entry may map a 2 MB page directly. Completed translations are kept in an eight-entry fully associative cache tagged by domain and page. A hit still resolves the domain, but it skips the three page-table reads. An invalidate strobe clears the whole cache or only one domain's entries.

Top module: `dmar_xlate`

## Requirements
- R1: The requester ID is split as bus = bits 15:8 and device/function = bits 7:0. The root entry is read at ROOT_BASE + bus*8. The context entry is read at (root entry bits 51:12 << 12) + devfn*8. Page-table entries are read at (table base << 12) + index*8, where the index comes from address bits 38:30, then 29:21, then 20:12. Each read returns a 64-bit entry.
- R2: Root entry bit 0 means present. Context entry bit 0 means a domain is assigned, bits 8:1 hold the domain ID and bits 51:12 hold the page-table root. If either bit 0 is clear, the response is fault code 1 and no further memory is read.
- R3: If any of device address bits 63:39 is set, the response is fault code 4 on the clock edge that accepts the request, and no memory is read.
- R4: A level-3 leaf returns the physical address {entry bits 51:12, address bits 11:0}.
- R5: A level-2 entry with bit 7 set is a 2 MB leaf and returns {entry bits 51:21, address bits 20:0}. Bit 7 has no effect at levels 1 and 3.
- R6: In a page-table entry, bit 0 grants read and bit 1 grants write. An entry with both bits clear is non-present: the walk stops with fault code 2 and reads nothing more.
- R7: If any entry on the path does not grant the request's direction, the response is fault code 3 and the walk stops at that entry.
- R8: A successful walk is cached with its domain, page and combined permissions. A later request with the same domain and page (the same 4 KB page, or anywhere in a cached 2 MB page) reads only the root and context entries. The response keeps code 3 when the cached permission forbids the direction. Another domain with the same address misses.
- R9: The cache holds eight entries and fills them in round-robin order, so the ninth distinct fill evicts the oldest one.
- R10: An inv_valid pulse with inv_all set clears every cache entry. With inv_all clear, it clears only entries whose domain equals inv_did.
- R11: Each accepted request produces exactly one single-cycle rsp_valid pulse, in request order. req_ready is low while a request is in progress. A fault reports rsp_fault=1 with a nonzero code and a zero address. A success reports rsp_fault=0 and code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Unit idle, request will be accepted |
| req_rid | input | 16 | Requester ID (bus, device, function) |
| req_addr | input | 64 | Device address |
| req_write | input | 1 | 1 = write, 0 = read |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_fault | output | 1 | Request refused |
| rsp_code | output | 3 | 0 ok, 1 no domain, 2 not present, 3 permission, 4 range |
| rsp_paddr | output | 52 | Translated physical address |
| mem_req_valid | output | 1 | Table read strobe |
| mem_req_addr | output | 52 | Table read address |
| mem_rsp_valid | input | 1 | Table read data strobe |
| mem_rsp_data | input | 64 | Table entry |
| inv_valid | input | 1 | Cache invalidate strobe |
| inv_all | input | 1 | Invalidate every entry |
| inv_did | input | 8 | Domain to invalidate when inv_all is 0 |

## Verification
The response to a walk, and to a no-domain fault, is registered on the same edge that consumes the deciding table entry. A cache hit responds exactly one edge after the context entry arrives. A range fault appears on the accepting edge. The bench records the edge of the last table reply and the edge of acceptance, and it requires these exact distances at every response. It also matches every table read address, in order, against the list its behavioural model predicts. It checks on the next cycle that no second pulse follows.

// File: rtl/dmar_pkg.sv
package dmar_pkg;
  localparam int VA_TOP   = 39;
  localparam int PG_SHIFT = 12;
  localparam int IDX_W    = 9;
  localparam int VPN_W    = VA_TOP - PG_SHIFT;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_NODOM   = 3'd1,
    FLT_NOTPRES = 3'd2,
    FLT_PERM    = 3'd3,
    FLT_RANGE   = 3'd4
  } flt_e;

  typedef enum logic [2:0] {S_IDLE, S_ROOT, S_CTX, S_LOOK, S_PT} walk_st_e;

  function automatic logic dir_ok(logic can_rd, logic can_wr, logic is_wr);
    return is_wr ? can_wr : can_rd;
  endfunction
endpackage

// File: rtl/dmar_tlb.sv
module dmar_tlb import dmar_pkg::*; #(
  parameter int DID_W   = 8,
  parameter int FRAME_W = 40,
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DID_W-1:0]   lk_did,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  output logic               lk_large,
  output logic               lk_r,
  output logic               lk_w,
  input  logic               fill_en,
  input  logic [DID_W-1:0]   fill_did,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic               fill_large,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_r,
  input  logic               fill_w,
  input  logic               inv_en,
  input  logic               inv_all,
  input  logic [DID_W-1:0]   inv_did
);
  localparam int SEL_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [DID_W-1:0]   t_did [ENTRIES];
  logic [VPN_W-1:0]   t_vpn [ENTRIES];
  logic               t_lg  [ENTRIES];
  logic [FRAME_W-1:0] t_fr  [ENTRIES];
  logic               t_r   [ENTRIES];
  logic               t_w   [ENTRIES];
  logic [SEL_W-1:0]   rr;
  logic [ENTRIES-1:0] match;
  logic [SEL_W-1:0]   sel;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic hi_eq, lo_eq;
    assign hi_eq    = t_vpn[g][VPN_W-1:IDX_W] == lk_vpn[VPN_W-1:IDX_W];
    assign lo_eq    = t_vpn[g][IDX_W-1:0] == lk_vpn[IDX_W-1:0];
    assign match[g] = vld[g] && (t_did[g] == lk_did) && hi_eq && (t_lg[g] || lo_eq);
  end

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = SEL_W'(i);
  end

  assign lk_hit   = |match;
  assign lk_frame = t_fr[sel];
  assign lk_large = t_lg[sel];
  assign lk_r     = t_r[sel];
  assign lk_w     = t_w[sel];

  always_ff @(posedge clk) begin
    if (fill_en) begin
      t_did[rr] <= fill_did;
      t_vpn[rr] <= fill_vpn;
      t_lg[rr]  <= fill_large;
      t_fr[rr]  <= fill_frame;
      t_r[rr]   <= fill_r;
      t_w[rr]   <= fill_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      rr  <= '0;
    end else begin
      if (fill_en) begin
        vld[rr] <= 1'b1;
        rr      <= (rr == SEL_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
      for (int i = 0; i < ENTRIES; i++) begin
        if (inv_en && (inv_all ||
            (((fill_en && rr == SEL_W'(i)) ? fill_did : t_did[i]) == inv_did)))
          vld[i] <= 1'b0;
      end
    end
  end

  assert_inv_all_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (inv_en && inv_all) |=> !lk_hit);
endmodule

// File: rtl/dmar_walk.sv
module dmar_walk import dmar_pkg::*; #(
  parameter int             PA_W      = 52,
  parameter int             DID_W     = 8,
  parameter logic [PA_W-1:0] ROOT_BASE = 'h1000,
  localparam int            FRAME_W   = PA_W - PG_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [15:0]        req_rid,
  input  logic [63:0]        req_addr,
  input  logic               req_write,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic [2:0]         rsp_code,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic               mem_req_valid,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [63:0]        mem_rsp_data,
  output logic [DID_W-1:0]   lk_did,
  output logic [VPN_W-1:0]   lk_vpn,
  input  logic               lk_hit,
  input  logic [FRAME_W-1:0] lk_frame,
  input  logic               lk_large,
  input  logic               lk_r,
  input  logic               lk_w,
  output logic               fill_en,
  output logic               fill_large,
  output logic [FRAME_W-1:0] fill_frame,
  output logic               fill_r,
  output logic               fill_w
);
  walk_st_e            st;
  logic [7:0]          devfn;
  logic [VA_TOP-1:0]   va;
  logic                wr;
  logic [DID_W-1:0]    did;
  logic [FRAME_W-1:0]  base;
  logic [1:0]          lvl;
  logic                acc_r, acc_w;

  logic                done, issue, nr, nw, big;
  flt_e                code;
  logic [PA_W-1:0]     pa, iaddr;
  logic [63:0]         e;
  logic                unused_bits;

  function automatic logic [IDX_W-1:0] idx_of(logic [1:0] l, logic [VA_TOP-1:0] v);
    case (l)
      2'd0:    return v[38:30];
      2'd1:    return v[29:21];
      default: return v[20:12];
    endcase
  endfunction

  assign e           = mem_rsp_data;
  assign unused_bits = ^{mem_rsp_data[63:PA_W], mem_rsp_data[11:DID_W+1]};
  assign req_ready   = (st == S_IDLE);
  assign lk_did      = did;
  assign lk_vpn      = va[VA_TOP-1:PG_SHIFT];
  assign nr          = acc_r & e[0];
  assign nw          = acc_w & e[1];
  assign big         = (lvl == 2'd1) && e[7];
  assign fill_large  = big;
  assign fill_frame  = e[PA_W-1:PG_SHIFT];
  assign fill_r      = nr;
  assign fill_w      = nw;

  always_comb begin
    done = 1'b0; issue = 1'b0; code = FLT_NONE;
    pa = '0; iaddr = '0; fill_en = 1'b0;
    case (st)
      S_IDLE: if (req_valid) begin
        if (|req_addr[63:VA_TOP]) begin
          done = 1'b1; code = FLT_RANGE;
        end else begin
          issue = 1'b1; iaddr = ROOT_BASE + PA_W'({req_rid[15:8], 3'b000});
        end
      end
      S_ROOT: if (mem_rsp_valid) begin
        if (!e[0]) begin
          done = 1'b1; code = FLT_NODOM;
        end else begin
          issue = 1'b1;
          iaddr = {e[PA_W-1:PG_SHIFT], 12'h000} + PA_W'({devfn, 3'b000});
        end
      end
      S_CTX: if (mem_rsp_valid && !e[0]) begin
        done = 1'b1; code = FLT_NODOM;
      end
      S_LOOK: if (lk_hit) begin
        done = 1'b1;
        if (!dir_ok(lk_r, lk_w, wr)) code = FLT_PERM;
        else if (lk_large) pa = {lk_frame[FRAME_W-1:IDX_W], va[20:0]};
        else pa = {lk_frame, va[11:0]};
      end else begin
        issue = 1'b1;
        iaddr = {base, 12'h000} + PA_W'({idx_of(2'd0, va), 3'b000});
      end
      S_PT: if (mem_rsp_valid) begin
        if (!(e[0] | e[1])) begin
          done = 1'b1; code = FLT_NOTPRES;
        end else if (!dir_ok(nr, nw, wr)) begin
          done = 1'b1; code = FLT_PERM;
        end else if (lvl == 2'd2 || big) begin
          done = 1'b1; fill_en = 1'b1;
          pa = big ? {e[PA_W-1:21], va[20:0]} : {e[PA_W-1:PG_SHIFT], va[11:0]};
        end else begin
          issue = 1'b1;
          iaddr = {e[PA_W-1:PG_SHIFT], 12'h000} + PA_W'({idx_of(lvl + 2'd1, va), 3'b000});
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; rsp_valid <= 1'b0; rsp_fault <= 1'b0; rsp_code <= '0;
      rsp_paddr <= '0; mem_req_valid <= 1'b0; mem_req_addr <= '0;
      devfn <= '0; va <= '0; wr <= 1'b0; did <= '0; base <= '0;
      lvl <= '0; acc_r <= 1'b0; acc_w <= 1'b0;
    end else begin
      rsp_valid     <= done;
      mem_req_valid <= issue;
      if (issue) mem_req_addr <= iaddr;
      if (done) begin
        rsp_fault <= (code != FLT_NONE);
        rsp_code  <= code;
        rsp_paddr <= pa;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          devfn <= req_rid[7:0]; va <= req_addr[VA_TOP-1:0]; wr <= req_write;
          acc_r <= 1'b1; acc_w <= 1'b1; lvl <= 2'd0;
          st <= done ? S_IDLE : S_ROOT;
        end
        S_ROOT: if (mem_rsp_valid) st <= done ? S_IDLE : S_CTX;
        S_CTX: if (mem_rsp_valid) begin
          if (done) st <= S_IDLE;
          else begin
            did <= e[DID_W:1]; base <= e[PA_W-1:PG_SHIFT]; st <= S_LOOK;
          end
        end
        S_LOOK: st <= done ? S_IDLE : S_PT;
        S_PT: if (mem_rsp_valid) begin
          if (done) st <= S_IDLE;
          else begin
            lvl <= lvl + 2'd1; acc_r <= nr; acc_w <= nw;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_range_fault_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && req_valid && |req_addr[63:VA_TOP]) |=>
      (rsp_valid && rsp_code == FLT_RANGE && !mem_req_valid));

  assert_no_domain_stop_R2: assert property (@(posedge clk) disable iff (rst)
    (st == S_CTX && mem_rsp_valid && !mem_rsp_data[0]) |=>
      (rsp_valid && rsp_code == FLT_NODOM && !mem_req_valid));

  assert_single_read_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_notpres_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_PT && mem_rsp_valid && !(mem_rsp_data[0] | mem_rsp_data[1])) |=>
      (rsp_valid && rsp_code == FLT_NOTPRES && req_ready));
endmodule

// File: rtl/dmar_xlate.sv
module dmar_xlate import dmar_pkg::*; #(
  parameter int              PA_W      = 52,
  parameter int              DID_W     = 8,
  parameter int              ENTRIES   = 8,
  parameter logic [PA_W-1:0] ROOT_BASE = 'h1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [15:0]      req_rid,
  input  logic [63:0]      req_addr,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [2:0]       rsp_code,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             mem_req_valid,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  input  logic             inv_valid,
  input  logic             inv_all,
  input  logic [DID_W-1:0] inv_did
);
  localparam int FRAME_W = PA_W - PG_SHIFT;

  logic [DID_W-1:0]   lk_did;
  logic [VPN_W-1:0]   lk_vpn;
  logic               lk_hit, lk_large, lk_r, lk_w;
  logic [FRAME_W-1:0] lk_frame, fill_frame;
  logic               fill_en, fill_large, fill_r, fill_w;

  dmar_walk #(.PA_W(PA_W), .DID_W(DID_W), .ROOT_BASE(ROOT_BASE)) u_walk (
    .clk, .rst, .req_valid, .req_ready, .req_rid, .req_addr, .req_write,
    .rsp_valid, .rsp_fault, .rsp_code, .rsp_paddr,
    .mem_req_valid, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
    .lk_did, .lk_vpn, .lk_hit, .lk_frame, .lk_large, .lk_r, .lk_w,
    .fill_en, .fill_large, .fill_frame, .fill_r, .fill_w
  );

  dmar_tlb #(.DID_W(DID_W), .FRAME_W(FRAME_W), .ENTRIES(ENTRIES)) u_tlb (
    .clk, .rst, .lk_did, .lk_vpn, .lk_hit, .lk_frame, .lk_large, .lk_r, .lk_w,
    .fill_en, .fill_did(lk_did), .fill_vpn(lk_vpn), .fill_large, .fill_frame,
    .fill_r, .fill_w, .inv_en(inv_valid), .inv_all, .inv_did
  );
endmodule

// File: tb/sim_dmar_xlate.sv
module sim_dmar_xlate;
  localparam logic [51:0] ROOT = 52'h1000;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [15:0] req_rid = '0;
  logic [63:0] req_addr = '0;
  logic rsp_valid, rsp_fault;
  logic [2:0] rsp_code;
  logic [51:0] rsp_paddr, mem_req_addr;
  logic mem_req_valid, mem_rsp_valid = 0;
  logic [63:0] mem_rsp_data = '0;
  logic inv_valid = 0, inv_all = 0;
  logic [7:0] inv_did = '0;

  dmar_xlate u0 (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, last_mrsp = 0, acc_cyc = 0;
  logic [63:0] mem [logic [51:0]];
  logic [51:0] exp_q [$];

  bit mv [8]; logic [7:0] mdid [8]; logic [26:0] mvpn [8]; bit mlg [8];
  logic [39:0] mfr [8]; bit mr [8]; bit mw [8]; int mrr = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [63:0] rd(logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] va(int l1, int l2, int l3, int off);
    return {25'h0, l1[8:0], l2[8:0], l3[8:0], off[11:0]};
  endfunction

  // Behavioural reference: predicts the read list, the response and cache contents.
  task automatic model(input logic [15:0] rid, input logic [63:0] a, input bit w,
                       output bit f, output int code, output logic [51:0] pa, output bit hit);
    logic [63:0] e; logic [39:0] base; logic [7:0] did; bit r, wp, big;
    f = 0; code = 0; pa = '0; hit = 0;
    if (a[63:39] != 0) begin f = 1; code = 4; return; end
    exp_q.push_back(ROOT + {41'h0, rid[15:8], 3'b0});
    e = rd(ROOT + {41'h0, rid[15:8], 3'b0});
    if (!e[0]) begin f = 1; code = 1; return; end
    exp_q.push_back({e[51:12], 12'h0} + {41'h0, rid[7:0], 3'b0});
    e = rd({e[51:12], 12'h0} + {41'h0, rid[7:0], 3'b0});
    if (!e[0]) begin f = 1; code = 1; return; end
    did = e[8:1]; base = e[51:12];
    for (int i = 0; i < 8; i++) begin
      if (!hit && mv[i] && mdid[i] == did &&
          (mlg[i] ? mvpn[i][26:9] == a[38:21] : mvpn[i] == a[38:12])) begin
        hit = 1;
        if (w ? !mw[i] : !mr[i]) begin f = 1; code = 3; end
        else pa = mlg[i] ? {mfr[i][39:9], a[20:0]} : {mfr[i], a[11:0]};
      end
    end
    if (hit) return;
    r = 1; wp = 1;
    for (int l = 0; l < 3; l++) begin
      logic [51:0] ea;
      ea = {base, 12'h0} + {40'h0, a[38 - 9*l -: 9], 3'b0};
      exp_q.push_back(ea);
      e = rd(ea);
      if (!(e[0] | e[1])) begin f = 1; code = 2; return; end
      r = r & e[0]; wp = wp & e[1];
      if (w ? !wp : !r) begin f = 1; code = 3; return; end
      big = (l == 1) && e[7];
      if (l == 2 || big) begin
        pa = big ? {e[51:21], a[20:0]} : {e[51:12], a[11:0]};
        mv[mrr] = 1; mdid[mrr] = did; mvpn[mrr] = a[38:12]; mlg[mrr] = big;
        mfr[mrr] = e[51:12]; mr[mrr] = r; mw[mrr] = wp; mrr = (mrr + 1) % 8;
        return;
      end
      base = e[51:12];
    end
  endtask

  // Edge bookkeeping for latency checks
  initial forever begin
    @(posedge clk);
    cyc++;
    if (mem_rsp_valid) last_mrsp = cyc;
    if (req_valid && req_ready) acc_cyc = cyc;
  end

  // Table memory responder, one-cycle turnaround, checks each read address (R1)
  initial begin
    bit pend = 0; logic [63:0] pdata = '0;
    forever begin
      @(negedge clk);
      if (pend) begin mem_rsp_valid = 1; mem_rsp_data = pdata; pend = 0; end
      else mem_rsp_valid = 0;
      if (mem_req_valid && !rst) begin
        if (exp_q.size() == 0) chk(0, "R1", "unexpected table read", mem_req_addr, 0);
        else begin
          logic [51:0] ex;
          ex = exp_q.pop_front();
          chk(mem_req_addr == ex, "R1", "table read address", mem_req_addr, ex);
        end
        pdata = rd(mem_req_addr); pend = 1;
      end
    end
  end

  task automatic run(input logic [15:0] rid, input logic [63:0] a, input bit w, input string tag);
    bit f, hit; int code, t; logic [51:0] pa;
    model(rid, a, w, f, code, pa, hit);
    @(negedge clk);
    req_valid = 1; req_rid = rid; req_addr = a; req_write = w;
    @(negedge clk);
    req_valid = 0;
    if (code != 4) chk(!req_ready, "R11", "req_ready while busy", req_ready, 0);
    t = 0;
    while (!rsp_valid && t < 200) begin @(negedge clk); t++; end
    if (!rsp_valid) begin
      chk(0, tag, "response timeout", 0, 1);
      return;
    end
    chk(rsp_fault == f, tag, "rsp_fault", rsp_fault, f);
    chk(rsp_code == code[2:0], tag, "rsp_code", rsp_code, code);
    chk(rsp_paddr == pa, tag, "rsp_paddr", rsp_paddr, pa);
    chk(exp_q.size() == 0, tag, "reads missing", exp_q.size(), 0);
    exp_q.delete();
    if (code == 4) chk(cyc == acc_cyc, "R3", "range fault latency", cyc - acc_cyc, 0);
    else if (hit) chk(cyc - last_mrsp == 1, "R8", "hit latency", cyc - last_mrsp, 1);
    else chk(cyc == last_mrsp, tag, "walk latency", cyc - last_mrsp, 0);
    @(negedge clk);
    chk(!rsp_valid, "R11", "single response pulse", rsp_valid, 0);
  endtask

  task automatic inval(input bit all, input logic [7:0] d);
    for (int i = 0; i < 8; i++) if (all || mdid[i] == d) mv[i] = 0;
    @(negedge clk); inv_valid = 1; inv_all = all; inv_did = d;
    @(negedge clk); inv_valid = 0; inv_all = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R11", "watchdog expired", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  localparam logic [15:0] D5 = 16'h0310, DNOD = 16'h0311, D6 = 16'h0318, BADBUS = 16'h0410;

  initial begin
    mem[ROOT + 52'h18]          = 64'h2001;
    mem[52'h2000 + 52'h10 * 8]  = 64'h3000 | (64'd5 << 1) | 1;
    mem[52'h2000 + 52'h11 * 8]  = 64'h3000 | (64'd7 << 1);
    mem[52'h2000 + 52'h18 * 8]  = 64'h3000 | (64'd6 << 1) | 1;
    mem[52'h3008]               = 64'h4003;
    mem[52'h4000 + 2 * 8]       = 64'h5003;
    mem[52'h4000 + 6 * 8]       = 64'h4000_0083;
    mem[52'h4000 + 7 * 8]       = 64'h6001;
    mem[52'h5000 + 3 * 8]       = 64'hABCDE001;
    mem[52'h5000 + 4 * 8]       = 64'h1_2345_6003;
    mem[52'h5000 + 8 * 8]       = 64'h9083;
    for (int k = 0; k < 10; k++) mem[52'h5000 + 52'(16 + k) * 8] = 64'h10_0003 + (64'(k) << 12);
    mem[52'h6000]               = 64'h8003;

    repeat (3) @(negedge clk);
    chk(rsp_valid == 0, "R11", "reset rsp_valid", rsp_valid, 0);
    chk(mem_req_valid == 0, "R1", "reset mem_req_valid", mem_req_valid, 0);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1, "R11", "ready after reset", req_ready, 1);

    run(D5, va(1, 2, 3, 12'hABC), 0, "R4");
    run(D5, va(1, 2, 3, 12'hABC), 0, "R8");
    run(D5, va(1, 2, 3, 12'h010), 1, "R7");
    run(D5, va(1, 2, 4, 12'h044), 1, "R4");
    run(D5, va(1, 2, 5, 0), 0, "R6");
    run(D5, va(1, 6, 9'h1F, 12'h123), 0, "R5");
    run(D5, va(1, 6, 9'h40, 12'h008), 1, "R5");
    run(D5, va(1, 2, 8, 12'h020), 0, "R5");
    run(D5, va(1, 7, 0, 0), 1, "R7");
    run(D5, va(1, 7, 0, 4), 0, "R4");
    run(D5, va(1, 7, 0, 8), 1, "R7");
    run(D5, va(2, 0, 0, 0), 0, "R6");
    run(DNOD, va(1, 2, 3, 0), 0, "R2");
    run(BADBUS, va(1, 2, 3, 0), 0, "R2");
    run(D5, 64'h1 << 39, 0, "R3");
    run(D5, (64'h1 << 63) | va(1, 2, 3, 0), 1, "R3");
    run(D6, va(1, 2, 3, 12'h0AB), 0, "R8");
    inval(0, 8'd5);
    run(D5, va(1, 2, 3, 12'h001), 0, "R10");
    run(D6, va(1, 2, 3, 12'h002), 0, "R10");
    inval(1, 8'd0);
    run(D6, va(1, 2, 3, 12'h003), 0, "R10");
    for (int k = 0; k < 10; k++) run(D5, va(1, 2, 16 + k, 12'h7), 0, "R9");
    run(D5, va(1, 2, 16, 12'h9), 0, "R9");
    run(D5, va(1, 2, 25, 12'h9), 0, "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule